// File: doc/BRIEF.md
# Framebuffer Scan-Out Display Controller

This block reads a true-colour picture from external memory and drives a TFT or VGA panel with it. A sync generator produces the video timing of one fixed mode: 640 visible pixels by 480 visible rows at 60 Hz with a 25 MHz pixel clock. For every visible pixel a word address is formed and a read is issued on a simple memory port. The returned 32-bit word is split into 8-bit red, green and blue levels that appear on the outputs together with the matching data-enable and the two active-low sync strobes.

Software controls the block through two 32-bit registers. One holds the framebuffer base address; only its upper 11 bits are stored, so the buffer sits on a 2 MiB boundary. The other holds an enable bit and a bit that turns the picture upside down by walking memory backwards. A memory row is always 1024 words long, but only its first 640 words are fetched. New base and rotation values are taken over only when a frame begins, so no frame mixes two settings. There is no palette and no other video mode.

All sizes (porches, sync widths, visible area, row stride, address width, kept base bits) are parameters; the defaults give the mode above.

Top module: `fb_scanout`

## Requirements
- R1: During and right after reset: mem_req is 0, de is 0, red/grn/blu are 0, hsync_n and vsync_n are 1, and both registers read as 0.
- R2: A write with reg_sel=0 stores bits 31:21 of reg_wdata as the base address; reg_rdata with reg_sel=0 returns those bits with bits 20:0 reading 0.
- R3: A write with reg_sel=1 stores bit 0 (enable) and bit 1 (rotate-180); reg_rdata with reg_sel=1 returns them in bits 1:0 with bits 31:2 reading 0. Writing 0 switches the display off.
- R4: From the second clock edge after the edge that samples a disabling write, mem_req stays 0; from the fourth such edge, de and red/grn/blu are 0 and hsync_n, vsync_n are 1, for as long as the display stays off.
- R5: A line lasts H_ACT+H_FP+H_SYN+H_BP cycles with hsync_n low for H_SYN cycles starting H_ACT+H_FP cycles into the line; a frame lasts V_ACT+V_FP+V_SYN+V_BP lines with vsync_n low for V_SYN lines starting V_ACT+V_FP lines in. hsync_n and vsync_n are never low while de is high.
- R6: Unrotated, the pixel at row y, column x is read from base + (y*1024 + x)*4, pixels of a line at consecutive addresses 4 apart.
- R7: Exactly H_ACT requests are made per visible row and none in blanking, so words H_ACT..1023 of each row are never read; de is high exactly two cycles after each request.
- R8: Rotated, the pixel at row y, column x is read from base + ((V_ACT-1-y)*1024 + (H_ACT-1-x))*4, so addresses of a line step down by 4.
- R9: mem_rdata is taken in the cycle after mem_req; two cycles after a request red=bits 23:16, grn=bits 15:8, blu=bits 7:0 of that word, bits 31:24 are ignored, and colours are 0 whenever de is 0.
- R10: Base and rotate values are adopted only at the first line of vertical blanking; enabling starts the timing at that line, so the first request after enabling comes (V_FP+V_SYN+V_BP) lines later, and a write during a frame changes no address of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 base address, 1 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory read request, one per visible pixel |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rdata | input | 32 | Returned word, valid the cycle after mem_req |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Visible-pixel qualifier |
| red | output | 8 | Red level |
| grn | output | 8 | Green level |
| blu | output | 8 | Blue level |

## Verification
A register write sampled at one edge is visible on reg_rdata from that edge on, but a pixel position reaches mem_req and mem_addr one edge after the timing counters hold it, and de, the syncs and the colours two edges after that. The bench's behavioural model keeps the three-deep queue of expected pixel records that this implies and compares every output at the falling edge of each cycle, where all of these registers are settled. Directed checks wait for vsync_n and the first request of a frame so that mid-frame writes, the rotated start address and the disabled window are sampled at a known frame position.

// File: rtl/fbsc_pkg.sv
`timescale 1ns/1ps
package fbsc_pkg;

    // Colour levels carried from the fetch stage to the outputs.
    typedef struct packed {
        logic [7:0] red;
        logic [7:0] grn;
        logic [7:0] blu;
    } rgb_t;

    // Video qualifiers carried down the pixel pipe.
    typedef struct packed {
        logic de;
        logic hs_n;
        logic vs_n;
    } vctl_t;

    localparam vctl_t VCTL_IDLE = '{de: 1'b0, hs_n: 1'b1, vs_n: 1'b1};

    // Split a memory word into colour levels; the top byte carries nothing.
    function automatic rgb_t word_to_rgb(input logic [31:0] w);
        rgb_t c;
        c.red = w[23:16];
        c.grn = w[15:8];
        c.blu = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/fbsc_regs.sv
`timescale 1ns/1ps
module fbsc_regs #(
    parameter int AW   = 32,
    parameter int KEEP = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          sel,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic [AW-1:0] base,
    output logic          en,
    output logic          rot
);
    localparam int LOW = AW - KEEP;

    logic [KEEP-1:0] base_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_hi <= '0;
            en      <= 1'b0;
            rot     <= 1'b0;
        end else if (we) begin
            if (sel) begin
                en  <= wdata[0];
                rot <= wdata[1];
            end else begin
                base_hi <= wdata[AW-1:LOW];
            end
        end
    end

    assign base  = {base_hi, {LOW{1'b0}}};
    assign rdata = sel ? {30'd0, rot, en} : 32'(base);

endmodule

// File: rtl/fbsc_timing.sv
`timescale 1ns/1ps
module fbsc_timing #(
    parameter int H_ACT = 640,
    parameter int H_FP  = 16,
    parameter int H_SYN = 96,
    parameter int H_BP  = 48,
    parameter int V_ACT = 480,
    parameter int V_FP  = 10,
    parameter int V_SYN = 2,
    parameter int V_BP  = 33,
    parameter int HW    = 10,
    parameter int VW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [HW-1:0] h,
    output logic [VW-1:0] v,
    output logic          active,
    output logic          hs,
    output logic          vs,
    output logic          frame_go
);
    localparam int H_TOT  = H_ACT + H_FP + H_SYN + H_BP;
    localparam int V_TOT  = V_ACT + V_FP + V_SYN + V_BP;
    localparam int HS_BEG = H_ACT + H_FP;
    localparam int HS_END = HS_BEG + H_SYN;
    localparam int VS_BEG = V_ACT + V_FP;
    localparam int VS_END = VS_BEG + V_SYN;

    // While off, the counters wait at the first blanking line, which is
    // also where a new frame adopts its settings.
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            h <= '0;
            v <= VW'(V_ACT);
        end else if (h == HW'(H_TOT - 1)) begin
            h <= '0;
            v <= (v == VW'(V_TOT - 1)) ? '0 : v + 1'b1;
        end else begin
            h <= h + 1'b1;
        end
    end

    assign active   = (h < HW'(H_ACT)) && (v < VW'(V_ACT));
    assign hs       = (h >= HW'(HS_BEG)) && (h < HW'(HS_END));
    assign vs       = (v >= VW'(VS_BEG)) && (v < VW'(VS_END));
    assign frame_go = en && (h == '0) && (v == VW'(V_ACT));

endmodule

// File: rtl/fbsc_addr.sv
`timescale 1ns/1ps
module fbsc_addr #(
    parameter int AW        = 32,
    parameter int ROW_WORDS = 1024,
    parameter int H_ACT     = 640,
    parameter int V_ACT     = 480,
    parameter int HW        = 10,
    parameter int VW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic          rot_in,
    input  logic [HW-1:0] h,
    input  logic [VW-1:0] v,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] act_base;
    logic          act_rot;
    logic [AW-1:0] row;
    logic [AW-1:0] col;

    // Frame-wide copy of the settings, refreshed once per frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_base <= '0;
            act_rot  <= 1'b0;
        end else if (load) begin
            act_base <= base_in;
            act_rot  <= rot_in;
        end
    end

    always_comb begin
        row  = act_rot ? AW'(V_ACT - 1) - AW'(v) : AW'(v);
        col  = act_rot ? AW'(H_ACT - 1) - AW'(h) : AW'(h);
        addr = act_base + ((row * AW'(ROW_WORDS) + col) << 2);
    end

endmodule

// File: rtl/fbsc_pipe.sv
`timescale 1ns/1ps
module fbsc_pipe
    import fbsc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          active,
    input  logic          hs,
    input  logic          vs,
    input  logic [AW-1:0] addr_in,
    input  logic [31:0]   mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output vctl_t         vout,
    output rgb_t          pix
);
    vctl_t s1;
    vctl_t s2;
    logic  fetch;

    assign fetch = en && active;

    // Stage 1: request issue. Stage 2: word in flight. Stage 3: outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req  <= 1'b0;
            mem_addr <= '0;
            s1       <= VCTL_IDLE;
            s2       <= VCTL_IDLE;
            vout     <= VCTL_IDLE;
            pix      <= '0;
        end else begin
            mem_req <= fetch;
            if (fetch) begin
                mem_addr <= addr_in;
            end
            s1.de   <= fetch;
            s1.hs_n <= !(en && hs);
            s1.vs_n <= !(en && vs);
            s2      <= s1;
            vout    <= s2;
            pix     <= s2.de ? word_to_rgb(mem_rdata) : '0;
        end
    end

endmodule

// File: rtl/fb_scanout.sv
`timescale 1ns/1ps
module fb_scanout
    import fbsc_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BASE_KEEP = 11,
    parameter int ROW_WORDS = 1024,
    parameter int H_ACT     = 640,
    parameter int H_FP      = 16,
    parameter int H_SYN     = 96,
    parameter int H_BP      = 48,
    parameter int V_ACT     = 480,
    parameter int V_FP      = 10,
    parameter int V_SYN     = 2,
    parameter int V_BP      = 33
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic          reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          de,
    output logic [7:0]    red,
    output logic [7:0]    grn,
    output logic [7:0]    blu
);
    localparam int HW = $clog2(H_ACT + H_FP + H_SYN + H_BP);
    localparam int VW = $clog2(V_ACT + V_FP + V_SYN + V_BP);

    logic [AW-1:0] reg_base;
    logic          ctl_en;
    logic          ctl_rot;
    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;
    logic          in_view;
    logic          hs_on;
    logic          vs_on;
    logic          frame_go;
    logic [AW-1:0] pix_addr;
    vctl_t         vout;
    rgb_t          pix;

    fbsc_regs #(.AW(AW), .KEEP(BASE_KEEP)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .base(reg_base), .en(ctl_en), .rot(ctl_rot)
    );

    fbsc_timing #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYN(H_SYN), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYN(V_SYN), .V_BP(V_BP),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst(rst), .en(ctl_en), .h(h_pos), .v(v_pos),
        .active(in_view), .hs(hs_on), .vs(vs_on), .frame_go(frame_go)
    );

    fbsc_addr #(
        .AW(AW), .ROW_WORDS(ROW_WORDS), .H_ACT(H_ACT), .V_ACT(V_ACT),
        .HW(HW), .VW(VW)
    ) u_addr (
        .clk(clk), .rst(rst), .load(frame_go), .base_in(reg_base),
        .rot_in(ctl_rot), .h(h_pos), .v(v_pos), .addr(pix_addr)
    );

    fbsc_pipe #(.AW(AW)) u_pipe (
        .clk(clk), .rst(rst), .en(ctl_en), .active(in_view),
        .hs(hs_on), .vs(vs_on), .addr_in(pix_addr), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .vout(vout), .pix(pix)
    );

    assign hsync_n = vout.hs_n;
    assign vsync_n = vout.vs_n;
    assign de      = vout.de;
    assign red     = pix.red;
    assign grn     = pix.grn;
    assign blu     = pix.blu;

endmodule

// File: rtl/fb_scanout_chk.sv
`timescale 1ns/1ps
module fb_scanout_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [23:0]   mem_rdata,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          de,
    input logic [7:0]    red,
    input logic [7:0]    grn,
    input logic [7:0]    blu
);
    // R4: no request in the cycle after the display is off
    a_r4_no_req_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mem_req);

    // R4: outputs idle once the pipe has drained
    a_r4_idle_outputs: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(en) && !$past(en, 2)) |=>
            (hsync_n && vsync_n && !de && {red, grn, blu} == 24'd0));

    // R5: syncs never overlap visible pixels
    a_r5_sync_outside_view: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n || !vsync_n) |-> !de);

    // R6, R8: consecutive requests step by one word
    a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |->
            (mem_addr == $past(mem_addr) + AW'(4) || mem_addr == $past(mem_addr) - AW'(4)));

    // R10: direction never changes within a line
    a_r10_dir_constant: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req) && $past(mem_req, 2)) |->
            (mem_addr - $past(mem_addr) == $past(mem_addr) - $past(mem_addr, 2)));

    // R7: every request becomes a visible pixel two cycles later
    a_r7_req_to_de: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ##2 de);

    // R9: colours are the low three bytes of the word returned last cycle
    a_r9_unpack: assert property (@(posedge clk) disable iff (rst)
        de |-> ({red, grn, blu} == $past(mem_rdata)));

    // R9: blank pixels are black
    a_r9_black_blank: assert property (@(posedge clk) disable iff (rst)
        !de |-> ({red, grn, blu} == 24'd0));

endmodule

bind fb_scanout fb_scanout_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .en(ctl_en), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata[23:0]), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
    .red(red), .grn(grn), .blu(blu)
);

// File: tb/tb_fb_scanout.sv
`timescale 1ns/1ps
module tb_fb_scanout;
    localparam int H_ACT = 8, H_FP = 2, H_SYN = 3, H_BP = 3;
    localparam int V_ACT = 4, V_FP = 1, V_SYN = 2, V_BP = 1;
    localparam int H_TOT = H_ACT + H_FP + H_SYN + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYN + V_BP;
    localparam int ROW   = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        hsync_n, vsync_n, de;
    logic [7:0]  red, grn, blu;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fb_scanout #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYN(H_SYN), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYN(V_SYN), .V_BP(V_BP),
        .ROW_WORDS(ROW)
    ) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .de(de), .red(red), .grn(grn), .blu(blu)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
    endfunction

    // Memory: returns the word in the cycle after the request.
    always @(posedge clk) begin
        if (rst) mem_rdata <= '0;
        else if (mem_req) mem_rdata <= memf(mem_addr);
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        bit          req;
        bit          hs_n;
        bit          vs_n;
        logic [31:0] addr;
    } ent_t;

    ent_t        q0, q1, q2;
    ent_t        idle_e;
    bit          edge_rst = 1'b1;
    int          mh, mv;
    bit          m_en, m_rot, a_rot;
    logic [31:0] m_base, a_base;
    bit          p_we, p_sel;
    logic [31:0] p_wdata;

    always @(posedge clk) edge_rst <= rst;

    always @(negedge clk) begin
        if (edge_rst) begin
            idle_e = '{req: 1'b0, hs_n: 1'b1, vs_n: 1'b1, addr: 32'd0};
            q0 = idle_e; q1 = idle_e; q2 = idle_e;
            mh = 0; mv = V_ACT;
            m_en = 0; m_rot = 0; a_rot = 0;
            m_base = '0; a_base = '0;
            chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
            chk("R1 de", {31'd0, de}, 32'd0);
            chk("R1 syncs", {30'd0, hsync_n, vsync_n}, 32'd3);
            chk("R1 rgb", {8'd0, red, grn, blu}, 32'd0);
            chk("R1 reg_rdata", reg_rdata, 32'd0);
        end else begin
            ent_t e;
            int   row, col;
            row    = a_rot ? (V_ACT - 1 - mv) : mv;
            col    = a_rot ? (H_ACT - 1 - mh) : mh;
            e.req  = m_en && (mh < H_ACT) && (mv < V_ACT);
            e.hs_n = !(m_en && (mh >= H_ACT + H_FP) && (mh < H_ACT + H_FP + H_SYN));
            e.vs_n = !(m_en && (mv >= V_ACT + V_FP) && (mv < V_ACT + V_FP + V_SYN));
            e.addr = a_base + 32'((row * ROW + col) * 4);
            q2 = q1; q1 = q0; q0 = e;
            if (m_en && mh == 0 && mv == V_ACT) begin
                a_base = m_base;
                a_rot  = m_rot;
            end
            if (!m_en) begin
                mh = 0; mv = V_ACT;
            end else if (mh == H_TOT - 1) begin
                mh = 0;
                mv = (mv == V_TOT - 1) ? 0 : mv + 1;
            end else begin
                mh = mh + 1;
            end
            if (p_we) begin
                if (p_sel) begin
                    m_en  = p_wdata[0];
                    m_rot = p_wdata[1];
                end else begin
                    m_base = p_wdata & 32'hFFE0_0000;
                end
            end
            chk("R7/R4 mem_req", {31'd0, mem_req}, {31'd0, q0.req});
            if (q0.req) chk("R6/R8/R10 mem_addr", mem_addr, q0.addr);
            chk("R7 de", {31'd0, de}, {31'd0, q2.req});
            chk("R5 hsync_n/vsync_n", {30'd0, hsync_n, vsync_n}, {30'd0, q2.hs_n, q2.vs_n});
            chk("R9 rgb", {8'd0, red, grn, blu}, q2.req ? {8'd0, memf(q2.addr)[23:0]} : 32'd0);
            chk("R2/R3 reg_rdata", reg_rdata, reg_sel ? {30'd0, m_rot, m_en} : m_base);
        end
        p_we = reg_we; p_sel = reg_sel; p_wdata = reg_wdata;
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic s, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic wait_req();
        do @(negedge clk); while (!mem_req);
    endtask

    task automatic wait_vs();
        do @(negedge clk); while (vsync_n);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (R1-related progress): actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        bit idle_ok;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R2: only the top 11 base bits are kept
        wr(1'b0, 32'h1234_5678);
        @(negedge clk);
        chk("R2 base readback", reg_rdata, 32'h1220_0000);

        // R3: enable with junk in upper bits, rotate off
        wr(1'b1, 32'hFFFF_FFFD);
        @(negedge clk);
        chk("R3 control readback", reg_rdata, 32'h0000_0001);

        // R6: first pixel of the first frame sits at the base
        wait_vs();
        wait_req();
        chk("R6 first address", mem_addr, 32'h1220_0000);

        // R10: base change in mid-frame does not touch this frame
        wr(1'b0, 32'h4020_0000);
        wait_req();
        chk("R10 mid-frame base held", {21'd0, mem_addr[31:21]}, 32'h0000_0091);

        // R8: rotation from the next frame on
        wr(1'b1, 32'h0000_0003);
        wait_vs();
        wait_req();
        chk("R8 rotated first address", mem_addr,
            32'h4020_0000 + 32'(((V_ACT - 1) * ROW + (H_ACT - 1)) * 4));
        repeat (2 * H_TOT * V_TOT + 10) @(posedge clk);

        // R4: display off
        wr(1'b1, 32'h0);
        repeat (3) @(negedge clk);
        idle_ok = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mem_req || de || !hsync_n || !vsync_n || {red, grn, blu} != 24'd0)
                idle_ok = 1'b0;
        end
        chk("R4 idle while off", {31'd0, idle_ok}, 32'd1);

        // R10: re-enable unrotated at a new base
        wr(1'b0, 32'h0000_0000);
        wr(1'b1, 32'h0000_0001);
        repeat (2 * H_TOT * V_TOT + 10) @(posedge clk);

        // R3: rotate bit stored while off, outputs stay idle (model)
        wr(1'b1, 32'h0000_0002);
        @(negedge clk);
        chk("R3 rotate-only readback", reg_rdata, 32'h0000_0002);
        repeat (50) @(posedge clk);
        finish_run();
    end

endmodule